// File: doc/BRIEF.md
# HDLC Transmit Descriptor Ring Sequencer

This block walks a circular table of transmit descriptors kept in a small on-chip descriptor memory. For each descriptor it reads a control/status word, a byte count and a 32-bit buffer address. It then fetches the buffer one byte at a time and hands the bytes to a downstream HDLC framer. When the buffer is finished, the block writes the control/status word back to close the descriptor. Flag insertion, bit stuffing, CRC arithmetic and line coding all belong to the framer.

Each descriptor carries its own control bits:
- A ring-end bit sends the walk back to slot 0.
- An end-of-frame bit marks the last buffer of a frame.
- A CRC-append choice is honoured only on that last buffer.
- A repeat bit keeps the descriptor armed after a clean pass.
- A notify bit raises a one-cycle event when the buffer is done.

If the framer reports an underrun, or the line grant drops while a buffer is being sent, the open descriptor is closed with the matching status bit and the rest of the frame is discarded. A descriptor that is not armed is polled again at a fixed interval.

The byte stream uses valid/ready. `fr_valid` stays high and `fr_data`, `fr_eof` and `fr_crc` stay unchanged until a cycle in which `fr_ready` is high; that cycle transfers the byte. The one exception is an error: the stream is then cut at once, because the frame is being abandoned. Descriptor memory and buffer memory are both synchronous reads with one cycle of latency.

Top module: `hdlc_txbd_seq`

## Requirements
- R1: Descriptor n sits at words 4n..4n+3 of the descriptor memory: control/status, byte count, buffer address bits 31:16, buffer address bits 15:0. Control bits: 15 armed, 13 ring end, 12 notify, 11 end of frame, 10 append CRC, 9 repeat. Status bits: 1 underrun, 0 grant lost. The bytes at address, address+1, … are streamed in order.
- R2: While `fr_valid` is high and `fr_ready` is low, with no error, `fr_valid` and `fr_data` hold on the next cycle.
- R3: After a descriptor with the ring-end bit is closed, the next descriptor read is slot 0; otherwise it is the following slot.
- R4: A descriptor whose armed bit is clear is neither sent nor closed. Its control word is read again every POLL_CYC+2 cycles until it is armed.
- R5: `fr_eof` is high only with the final byte of a buffer whose end-of-frame bit is set.
- R6: `fr_crc` equals the append-CRC bit on an end-of-frame byte and is low on every other byte, whatever the bit holds.
- R7: On close, the control word is written back with the armed bit cleared, unless repeat is set and no error occurred. The two status bits are written with the outcome of this pass.
- R8: On close with notify set, `evt_sent` pulses for a clean pass and `evt_err` pulses for an errored pass. With notify clear, neither pulses.
- R9: `fr_underrun` during a buffer stops that buffer, sets status bit 1 and clears the armed bit even when repeat is set.
- R10: `line_grant` low during a buffer stops it and sets status bit 0 in the descriptor that is open at that moment.
- R11: After an error on a buffer without end of frame, the following descriptors up to and including the next one with end of frame are closed with the armed bit clear, with no bytes and no events.
- R12: A byte count of zero sends no byte, and the descriptor is closed right after its fetch.
- R13: During reset, `fr_valid`, `dm_wr`, `bb_rd`, `evt_sent` and `evt_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dm_rd | output | 1 | Descriptor memory read strobe |
| dm_wr | output | 1 | Descriptor memory write strobe |
| dm_addr | output | DM_AW | Descriptor memory word address |
| dm_wdata | output | 16 | Descriptor memory write word |
| dm_rdata | input | 16 | Descriptor memory read word, one cycle after dm_rd |
| bb_rd | output | 1 | Buffer byte read strobe |
| bb_addr | output | 32 | Buffer byte address |
| bb_rdata | input | 8 | Buffer byte, one cycle after bb_rd |
| fr_valid | output | 1 | Byte offered to the framer |
| fr_ready | input | 1 | Framer accepts the offered byte |
| fr_data | output | 8 | Byte to the framer |
| fr_eof | output | 1 | Byte is the last of its frame |
| fr_crc | output | 1 | Framer appends CRC after this end-of-frame byte |
| line_grant | input | 1 | CTS or layer-1 grant, high while transmission is allowed |
| fr_underrun | input | 1 | Framer ran out of data in mid-frame |
| evt_sent | output | 1 | One-cycle pulse: notified buffer closed cleanly |
| evt_err | output | 1 | One-cycle pulse: notified buffer closed with an error |

## Verification
The bench runs several descriptor tables.
- A two-buffer frame followed by a one-buffer frame, with the framer stalling every third cycle. This separates end-of-frame placement from CRC handling on non-final buffers, shows that bytes hold through stalls, and shows the return to slot 0.
- A single repeating descriptor that wraps onto itself. This shows that the armed bit survives a clean close.
- An underrun two bytes into a repeating, non-final buffer. This distinguishes the error close and its event from the silent skip up to the next end of frame.
- A grant loss in the second buffer of a frame. This shows that the status lands on the open descriptor and not on the earlier one.
- A zero-length descriptor that starts unarmed. This measures the poll interval, and confirms that nothing is closed until the descriptor is armed.

// File: rtl/hdlc_txbd_pkg.sv
`timescale 1ns/1ps
package hdlc_txbd_pkg;

  typedef enum logic [2:0] {
    S_F0,    // request control word
    S_F1,    // capture control, request count
    S_F2,    // capture count, request address high
    S_F3,    // capture address high, request address low
    S_F4,    // capture address low, dispatch
    S_SEND,  // bytes flowing to the framer
    S_CLOSE, // write control word back
    S_POLL   // waiting on an unarmed descriptor
  } seq_st_t;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned BIT_RDY  = 15;
  localparam int unsigned BIT_WRAP = 13;
  localparam int unsigned BIT_INT  = 12;
  localparam int unsigned BIT_LAST = 11;
  localparam int unsigned BIT_CRC  = 10;
  localparam int unsigned BIT_CONT = 9;
  localparam int unsigned BIT_URUN = 1;
  localparam int unsigned BIT_CTSL = 0;

endpackage

// File: rtl/hdlc_txbd_poll.sv
`timescale 1ns/1ps
module hdlc_txbd_poll #(
  parameter int unsigned POLL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int unsigned CW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam logic [CW-1:0] END_CNT = CW'(POLL_CYC - 1);

  logic          run;
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == END_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (cnt == END_CNT) run <= 1'b0;
      else                cnt <= cnt + 1'b1;
    end
  end

  // R4: the sequencer never re-arms the interval timer while it runs
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run);

endmodule

// File: rtl/hdlc_txbd_mover.sv
`timescale 1ns/1ps
module hdlc_txbd_mover #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              start_last,
  input  logic              start_crc,
  input  logic              abort,
  output logic              bb_rd,
  output logic [ADDR_W-1:0] bb_addr,
  input  logic [7:0]        bb_rdata,
  output logic              fr_valid,
  input  logic              fr_ready,
  output logic [7:0]        fr_data,
  output logic              fr_eof,
  output logic              fr_crc,
  output logic              done
);
  logic              active, pend, hv, hlast, last_r, crc_r;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  rem;
  logic [7:0]        hd;
  logic              take, issue;

  assign take  = hv && fr_ready;
  assign issue = active && !abort && !pend && (!hv || take) && (rem != '0);

  assign bb_rd    = issue;
  assign bb_addr  = addr;
  assign fr_valid = hv;
  assign fr_data  = hd;
  assign fr_eof   = hv && hlast && last_r;
  assign fr_crc   = fr_eof && crc_r;
  assign done     = take && hlast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pend   <= 1'b0;
      hv     <= 1'b0;
      hlast  <= 1'b0;
      last_r <= 1'b0;
      crc_r  <= 1'b0;
      addr   <= '0;
      rem    <= '0;
      hd     <= '0;
    end else if (start) begin
      active <= 1'b1;
      pend   <= 1'b0;
      hv     <= 1'b0;
      hlast  <= 1'b0;
      last_r <= start_last;
      crc_r  <= start_crc;
      addr   <= start_ptr;
      rem    <= start_len;
    end else if (abort) begin
      active <= 1'b0;
      pend   <= 1'b0;
      hv     <= 1'b0;
    end else if (active) begin
      if (pend) begin
        hv    <= 1'b1;
        hd    <= bb_rdata;
        hlast <= (rem == '0);
        pend  <= 1'b0;
      end else if (take) begin
        hv <= 1'b0;
      end
      if (issue) begin
        pend <= 1'b1;
        addr <= addr + 1'b1;
        rem  <= rem - 1'b1;
      end
      if (take && hlast) active <= 1'b0;
    end
  end

  // R2: an offered byte is held until the framer takes it
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_ready && !abort) |=> (fr_valid && $stable(fr_data)));

endmodule

// File: rtl/hdlc_txbd_seq.sv
`timescale 1ns/1ps
module hdlc_txbd_seq
  import hdlc_txbd_pkg::*;
#(
  parameter int unsigned DM_AW    = 8,
  parameter int unsigned POLL_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              dm_rd,
  output logic              dm_wr,
  output logic [DM_AW-1:0]  dm_addr,
  output logic [WORD_W-1:0] dm_wdata,
  input  logic [WORD_W-1:0] dm_rdata,
  output logic              bb_rd,
  output logic [31:0]       bb_addr,
  input  logic [7:0]        bb_rdata,
  output logic              fr_valid,
  input  logic              fr_ready,
  output logic [7:0]        fr_data,
  output logic              fr_eof,
  output logic              fr_crc,
  input  logic              line_grant,
  input  logic              fr_underrun,
  output logic              evt_sent,
  output logic              evt_err
);
  localparam int unsigned IW = DM_AW - 2;

  seq_st_t           st;
  logic [IW-1:0]     idx;
  logic [WORD_W-1:0] w0_r, len_r, ptr_hi;
  logic              skip, err_u, err_c, err_any;
  logic [WORD_W-1:0] close_word;
  logic              poll_start, poll_done;
  logic              mv_start, mv_abort, mv_done;

  assign err_any    = err_u || err_c;
  assign poll_start = (st == S_F1) && !dm_rdata[BIT_RDY];
  assign mv_start   = (st == S_F4) && !skip && (len_r != '0);
  assign mv_abort   = (st == S_SEND) && (fr_underrun || !line_grant);

  always_comb begin
    close_word           = w0_r;
    close_word[BIT_RDY]  = w0_r[BIT_CONT] && !err_any && !skip;
    close_word[BIT_URUN] = err_u;
    close_word[BIT_CTSL] = err_c;
  end

  always_comb begin
    dm_rd    = 1'b0;
    dm_wr    = 1'b0;
    dm_addr  = {idx, 2'd0};
    dm_wdata = close_word;
    unique case (st)
      S_F0:    dm_rd = 1'b1;
      S_F1:    begin dm_rd = 1'b1; dm_addr = {idx, 2'd1}; end
      S_F2:    begin dm_rd = 1'b1; dm_addr = {idx, 2'd2}; end
      S_F3:    begin dm_rd = 1'b1; dm_addr = {idx, 2'd3}; end
      S_CLOSE: dm_wr = 1'b1;
      default: ;
    endcase
  end

  assign evt_sent = (st == S_CLOSE) && !skip && w0_r[BIT_INT] && !err_any;
  assign evt_err  = (st == S_CLOSE) && !skip && w0_r[BIT_INT] && err_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_F0;
      idx    <= '0;
      w0_r   <= '0;
      len_r  <= '0;
      ptr_hi <= '0;
      skip   <= 1'b0;
      err_u  <= 1'b0;
      err_c  <= 1'b0;
    end else begin
      unique case (st)
        S_F0: st <= S_F1;
        S_F1: begin
          w0_r <= dm_rdata;
          st   <= dm_rdata[BIT_RDY] ? S_F2 : S_POLL;
        end
        S_F2: begin len_r  <= dm_rdata; st <= S_F3; end
        S_F3: begin ptr_hi <= dm_rdata; st <= S_F4; end
        S_F4: st <= mv_start ? S_SEND : S_CLOSE;
        S_SEND: begin
          if (mv_abort) begin
            err_u <= fr_underrun;
            err_c <= !line_grant;
            st    <= S_CLOSE;
          end else if (mv_done) begin
            st <= S_CLOSE;
          end
        end
        S_CLOSE: begin
          if (skip && w0_r[BIT_LAST])                 skip <= 1'b0;
          else if (!skip && err_any && !w0_r[BIT_LAST]) skip <= 1'b1;
          err_u <= 1'b0;
          err_c <= 1'b0;
          idx   <= w0_r[BIT_WRAP] ? '0 : idx + 1'b1;
          st    <= S_F0;
        end
        S_POLL: if (poll_done) st <= S_F0;
        default: st <= S_F0;
      endcase
    end
  end

  hdlc_txbd_poll #(.POLL_CYC(POLL_CYC)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (poll_start),
    .expired (poll_done)
  );

  hdlc_txbd_mover #(.LEN_W(WORD_W), .ADDR_W(32)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (mv_start),
    .start_ptr  ({ptr_hi, dm_rdata}),
    .start_len  (len_r),
    .start_last (w0_r[BIT_LAST]),
    .start_crc  (w0_r[BIT_CRC]),
    .abort      (mv_abort),
    .bb_rd      (bb_rd),
    .bb_addr    (bb_addr),
    .bb_rdata   (bb_rdata),
    .fr_valid   (fr_valid),
    .fr_ready   (fr_ready),
    .fr_data    (fr_data),
    .fr_eof     (fr_eof),
    .fr_crc     (fr_crc),
    .done       (mv_done)
  );

  // R1: the descriptor port never reads and writes in the same cycle
  a_r1_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_rd && dm_wr));
  // R6: a CRC request only rides on an end-of-frame byte
  a_r6_crc_eof: assert property (@(posedge clk) disable iff (!rst_n)
    fr_crc |-> fr_eof);
  // R7: any error status written back leaves the descriptor disarmed
  a_r7_err_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_wr && (dm_wdata[BIT_URUN] || dm_wdata[BIT_CTSL])) |-> !dm_wdata[BIT_RDY]);
  // R8: events only accompany a descriptor close
  a_r8_evt_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sent || evt_err) |-> dm_wr);
  // R4: while waiting on an unarmed descriptor nothing moves
  a_r4_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (!dm_rd && !dm_wr && !fr_valid));
  // R11: no byte is offered while the frame remainder is being skipped
  a_r11_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !fr_valid);

endmodule

// File: tb/hdlc_txbd_seq_bench.sv
`timescale 1ns/1ps
module hdlc_txbd_seq_bench;
  localparam int DM_AW = 6;
  localparam int POLL  = 6;
  localparam logic [15:0] RDY = 16'h8000, WRP = 16'h2000, INTR = 16'h1000,
                          LST = 16'h0800, CRC = 16'h0400, CNT = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             dm_rd, dm_wr, bb_rd, fr_valid, fr_eof, fr_crc, evt_sent, evt_err;
  logic [DM_AW-1:0] dm_addr;
  logic [15:0]      dm_wdata, dm_rdata;
  logic [31:0]      bb_addr;
  logic [7:0]       bb_rdata, fr_data;
  logic             fr_ready = 1'b0, line_grant = 1'b1, fr_underrun = 1'b0;

  hdlc_txbd_seq #(.DM_AW(DM_AW), .POLL_CYC(POLL)) u_hdlc_txbd_seq (
    .clk(clk), .rst_n(rst_n), .dm_rd(dm_rd), .dm_wr(dm_wr), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .bb_rd(bb_rd), .bb_addr(bb_addr),
    .bb_rdata(bb_rdata), .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data),
    .fr_eof(fr_eof), .fr_crc(fr_crc), .line_grant(line_grant),
    .fr_underrun(fr_underrun), .evt_sent(evt_sent), .evt_err(evt_err));

  logic [15:0] mem [0:63];
  logic [15:0] sh  [0:63];

  always @(posedge clk) begin
    if (dm_rd) dm_rdata <= mem[dm_addr];
    if (dm_wr) mem[dm_addr] <= dm_wdata;
    if (bb_rd) bb_rdata <= bb_addr[7:0] ^ 8'h5A;
  end

  int compared = 0, mism = 0;
  logic [9:0]  q_b[$];
  logic [31:0] q_w[$];
  int          q_e[$];
  string tag = "R13";
  int rmode = 0, inj_at = -1, inj_kind = 0, acc = 0, cyc = 0;
  bit inj_pend = 0, inj_now = 0, stall_prev = 0, finished = 0;
  logic [7:0] stall_data = '0;
  int rd0_cnt = 0, rd0_last = 0, rd0_prev = 0, wr_cnt = 0;
  logic [DM_AW-1:0] rd0_addr = '0;

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mism++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // framer model and per-cycle comparison against the expected queues
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    rdy = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
    inj_now = inj_pend;
    if (inj_pend) begin
      rdy = 1'b0;
      fr_underrun = (inj_kind == 1);
      line_grant  = (inj_kind != 2);
      inj_pend = 0;
    end else begin
      fr_underrun = 1'b0;
      line_grant  = 1'b1;
    end
    if (rst_n) begin
      if (stall_prev) chk("R2", "byte held under stall", {fr_valid, fr_data}, {1'b1, stall_data});
      if (fr_valid && rdy) begin
        if (q_b.size() == 0) chk(tag, "unexpected byte", {fr_eof, fr_crc, fr_data}, 32'hFFFF);
        else begin
          chk(tag, "R1 R5 R6 byte", {fr_eof, fr_crc, fr_data}, q_b.pop_front());
          acc++;
          if (acc == inj_at) inj_pend = 1;
        end
      end
      stall_prev = fr_valid && !rdy && !inj_now;
      stall_data = fr_data;
      if (dm_wr) begin
        wr_cnt++;
        if (q_w.size() == 0) chk(tag, "unexpected close", {16'(dm_addr), dm_wdata}, 32'hFFFF_FFFF);
        else chk(tag, "R7 close word", {16'(dm_addr), dm_wdata}, q_w.pop_front());
      end
      if (evt_sent || evt_err) begin
        if (q_e.size() == 0) chk(tag, "unexpected event", {evt_err, evt_sent}, 0);
        else chk(tag, "R8 event", {evt_err, evt_sent}, q_e.pop_front());
      end
      if (dm_rd && dm_addr[1:0] == 2'd0) begin
        rd0_prev = rd0_last; rd0_last = cyc; rd0_addr = dm_addr; rd0_cnt++;
      end
    end else begin
      stall_prev = 0;
    end
    fr_ready = rdy;
  end

  // behavioural walk of the table producing expected bytes, closes and events
  task automatic walk(int steps, int e_idx, int e_after, int e_kind);
    int idx = 0;
    bit skip = 0, used = 0;
    for (int s = 0; s < steps; s++) begin
      logic [15:0] w, nw;
      logic [31:0] p, a;
      logic lst, eb, cb;
      int len, n, e;
      w = sh[idx*4]; len = int'(sh[idx*4+1]); p = {sh[idx*4+2], sh[idx*4+3]};
      lst = w[11];
      if (skip) begin
        nw = w & 16'h7FFC;
        if (lst) skip = 0;
      end else begin
        n = len; e = 0;
        if (idx == e_idx && !used) begin n = e_after; e = e_kind; used = 1; end
        for (int i = 0; i < n; i++) begin
          a  = p + i;
          eb = (e == 0) && (i == len - 1) && lst;
          cb = eb && w[10];
          q_b.push_back({eb, cb, a[7:0] ^ 8'h5A});
        end
        nw = w & 16'hFFFC;
        if (e == 1) nw[1] = 1'b1;
        if (e == 2) nw[0] = 1'b1;
        nw[15] = w[9] && (e == 0);
        if (w[12]) q_e.push_back(e != 0 ? 2 : 1);
        if (e != 0 && !lst) skip = 1;
      end
      q_w.push_back({16'(idx*4), nw});
      sh[idx*4] = nw;
      idx = w[13] ? 0 : idx + 1;
    end
  endtask

  task automatic set_bd(int i, logic [15:0] w, logic [15:0] len, logic [31:0] p);
    mem[i*4] = w; mem[i*4+1] = len; mem[i*4+2] = p[31:16]; mem[i*4+3] = p[15:0];
    sh[i*4]  = w; sh[i*4+1]  = len; sh[i*4+2]  = p[31:16]; sh[i*4+3]  = p[15:0];
  endtask

  task automatic begin_test(string t, int rm);
    rst_n = 1'b0;
    q_b.delete(); q_w.delete(); q_e.delete();
    inj_at = -1; inj_kind = 0; acc = 0; inj_pend = 0;
    rd0_cnt = 0; rd0_last = 0; rd0_prev = 0; wr_cnt = 0;
    for (int i = 0; i < 64; i++) begin mem[i] = '0; sh[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R13", "outputs in reset", {fr_valid, dm_wr, bb_rd, evt_sent, evt_err}, 0);
    tag = t; rmode = rm;
  endtask

  task automatic go();
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic wait_empty(int limit);
    int n = 0;
    while ((q_b.size() + q_w.size() + q_e.size()) != 0 && n < limit) begin
      @(posedge clk); n++;
    end
    chk(tag, "expected traffic drained", q_b.size() + q_w.size() + q_e.size(), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mism++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  end

  initial begin : tests
    int c;
    // T1: two-buffer frame then one-buffer frame, stalling framer, ring end
    begin_test("R1 R3 R5 R6 R7 R8", 1);
    set_bd(0, RDY | INTR | CRC, 16'd3, 32'h0000_0100);
    set_bd(1, RDY | INTR | LST | CRC, 16'd2, 32'h0001_0200);
    set_bd(2, RDY | LST | WRP, 16'd1, 32'h0000_03FE);
    walk(3, -1, 0, 0);
    go();
    wait_empty(2000);
    c = rd0_cnt;
    for (int k = 0; k < 20 && rd0_cnt == c; k++) @(posedge clk);
    chk("R3", "slot read after ring end", 32'(rd0_addr), 0);
    repeat (30) @(posedge clk);

    // T2: repeating descriptor wrapping onto itself
    begin_test("R3 R7 R8", 0);
    set_bd(0, RDY | CNT | LST | WRP | INTR, 16'd2, 32'h0000_0040);
    walk(3, -1, 0, 0);
    go();
    wait_empty(2000);

    // T3: underrun inside a repeating non-final buffer, then skip to end of frame
    begin_test("R9 R11 R8", 1);
    set_bd(0, RDY | INTR | CNT, 16'd4, 32'h0000_0500);
    set_bd(1, RDY, 16'd2, 32'h0000_0600);
    set_bd(2, RDY | LST, 16'd2, 32'h0000_0700);
    set_bd(3, RDY | LST | WRP | INTR, 16'd1, 32'h0000_0800);
    inj_kind = 1; inj_at = 2;
    walk(4, 0, 2, 1);
    go();
    wait_empty(2000);
    repeat (20) @(posedge clk);

    // T4: grant lost in the second buffer of a frame
    begin_test("R10 R8", 0);
    set_bd(0, RDY, 16'd2, 32'h0000_0900);
    set_bd(1, RDY | LST | INTR | WRP, 16'd3, 32'h0000_0A00);
    inj_kind = 2; inj_at = 3;
    walk(2, 1, 1, 2);
    go();
    wait_empty(2000);
    repeat (20) @(posedge clk);

    // T5: zero-length descriptor that starts unarmed
    begin_test("R4 R12 R8", 0);
    set_bd(0, RDY | INTR, 16'd0, 32'h0000_0000);
    set_bd(1, RDY | LST | WRP, 16'd1, 32'h0000_0B00);
    walk(2, -1, 0, 0);
    mem[0] = INTR;
    go();
    repeat (40) @(posedge clk);
    #1;
    chk("R4", "poll interval", rd0_last - rd0_prev, POLL + 2);
    chk("R4", "no close while unarmed", wr_cnt, 0);
    chk("R4", "polling stays on slot 0", 32'(rd0_addr), 0);
    mem[0] = RDY | INTR;
    wait_empty(2000);
    repeat (20) @(posedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

endmodule